// File: doc/BRIEF.md
# Vectored Programmable Interrupt Controller

This block gathers a set of interrupt sources into a single request line toward the processor. Each source has its own configuration word, written and read through a small register port. The word holds:

- an enable;
- a three-bit priority;
- a base vector;
- a choice between level and edge sensing;
- a flag that substitutes the source's live cause code into the low bits of the vector.

Software masks one device by clearing its enable. It never has to touch the processor's global interrupt level.

When the processor runs an acknowledge cycle, the controller picks the winner from the sources that are pending, enabled and at a non-zero priority. The winner has the highest priority level. Ties at that level are broken round-robin. The controller returns the winner's vector on the next cycle, with no software acknowledge step. A latched edge request is dropped by hardware as part of the acknowledge. If nothing is eligible, a fixed spurious vector comes back instead.

Top module: `vpic`

## Requirements
- R1: After reset every configuration word reads zero, all enables are clear, `irq_out` is low and `vec_valid` is low.
- R2: A configuration word at address i (i < N_SRC) reads back bits 13:0 exactly as written, and its other bits read zero. The fields are: base vector [7:0], priority [10:8], enable [11], edge mode [12], cause select [13].
- R3: A pending source whose enable is clear never raises `irq_out` and never wins an acknowledge. Its pending bit is still visible in the status word.
- R4: A source at priority 0 is never forwarded, even when it is enabled and pending.
- R5: `irq_out` is high one cycle after a level source that is enabled, pending and at a non-zero priority is present, and low one cycle after no such source remains.
- R6: At an acknowledge (`iack` high for one clock), the winner is the eligible source with the numerically highest priority. Its vector appears on `vec_out` the next cycle together with a one-cycle `vec_valid`. `vec_out` holds its value between acknowledges.
- R7: Sources that tie at the winning level are granted round-robin. After reset the search starts just above source 0. After each grant, the search for that level starts just above the granted source.
- R8: When a source's cause select is set, bits [1:0] of its returned vector are replaced by that source's two `src_cause` bits.
- R9: An edge-mode source latches a rising input as pending. That pending bit is cleared by the acknowledge that grants it and stays clear while the input holds high. A level-mode source's pending bit follows its input.
- R10: An acknowledge with no eligible source returns the spurious vector 0xFF.
- R11: Reading address N_SRC returns the pending bit of every source, with source i in bit i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_irq | input | N_SRC | Interrupt inputs, one per source |
| src_cause | input | N_SRC*CAUSE_W | Cause code of each source, source i at bits [i*CAUSE_W +: CAUSE_W] |
| cfg_addr | input | ADDR_W | Register address |
| cfg_we | input | 1 | Write strobe |
| cfg_wdata | input | DATA_W | Write data |
| cfg_rdata | output | DATA_W | Read data, combinational from cfg_addr |
| irq_out | output | 1 | Request to the processor |
| iack | input | 1 | Acknowledge strobe, one cycle |
| vec_valid | output | 1 | Vector valid, the cycle after iack |
| vec_out | output | VEC_W | Returned vector |

## Verification
A stale round-robin pointer shows up as a wrong vector on the very next acknowledge at a tied level. The table sequences therefore repeat the same input pattern so that the rotation order is visible. A pending latch that fails to clear on acknowledge shows at once in the status word, and it keeps `irq_out` high one cycle later. A wrong priority comparison or a wrong mask appears in the vector of the first acknowledge that mixes the levels involved.

// File: rtl/vpic.sv
module vpic #(
  parameter int N_SRC   = 8,
  parameter int VEC_W   = 8,
  parameter int PRI_W   = 3,
  parameter int CAUSE_W = 2,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = $clog2(N_SRC + 2),
  parameter logic [VEC_W-1:0] SPUR_VEC = '1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_SRC-1:0]           src_irq,
  input  logic [N_SRC*CAUSE_W-1:0]   src_cause,
  input  logic [ADDR_W-1:0]          cfg_addr,
  input  logic                       cfg_we,
  input  logic [DATA_W-1:0]          cfg_wdata,
  output logic [DATA_W-1:0]          cfg_rdata,
  output logic                       irq_out,
  input  logic                       iack,
  output logic                       vec_valid,
  output logic [VEC_W-1:0]           vec_out
);
  localparam int IDX_W  = $clog2(N_SRC);
  localparam int LEVELS = 1 << PRI_W;
  localparam int EN_B   = VEC_W + PRI_W;
  localparam int CFG_W  = VEC_W + PRI_W + 3;

  logic [VEC_W-1:0] base_q [N_SRC];
  logic [PRI_W-1:0] pri_q  [N_SRC];
  logic [IDX_W-1:0] rr_q   [LEVELS];
  logic [N_SRC-1:0] en_q, edge_q, csel_q, src_d, edge_pend;
  logic [N_SRC-1:0] pend, elig, clr;
  logic [PRI_W-1:0] best_pri;
  logic [IDX_W-1:0] win;
  logic             any;
  logic [VEC_W-1:0] win_vec;

  assign pend = (edge_q & edge_pend) | (~edge_q & src_irq);
  always_comb
    for (int i = 0; i < N_SRC; i++)
      elig[i] = pend[i] & en_q[i] & (pri_q[i] != '0);
  assign any = |elig;

  always_comb begin
    best_pri = '0;
    for (int i = 0; i < N_SRC; i++)
      if (elig[i] && pri_q[i] > best_pri) best_pri = pri_q[i];
  end

  always_comb begin
    logic found;
    int   j;
    win   = '0;
    found = 1'b0;
    for (int k = 1; k <= N_SRC; k++) begin
      j = int'(rr_q[best_pri]) + k;
      if (j >= N_SRC) j = j - N_SRC;
      if (!found && elig[j] && pri_q[j] == best_pri) begin
        win   = IDX_W'(j);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    win_vec = base_q[win];
    if (csel_q[win]) win_vec[CAUSE_W-1:0] = src_cause[win*CAUSE_W +: CAUSE_W];
  end

  always_comb begin
    clr = '0;
    if (iack && any) clr[win] = edge_q[win];
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == ADDR_W'(N_SRC))
      cfg_rdata = DATA_W'(pend);
    else
      for (int i = 0; i < N_SRC; i++)
        if (cfg_addr == ADDR_W'(i))
          cfg_rdata = DATA_W'({csel_q[i], edge_q[i], en_q[i], pri_q[i], base_q[i]});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= '0;
      edge_q    <= '0;
      csel_q    <= '0;
      src_d     <= '0;
      edge_pend <= '0;
      irq_out   <= 1'b0;
      vec_valid <= 1'b0;
      vec_out   <= SPUR_VEC;
      for (int i = 0; i < N_SRC; i++) begin
        base_q[i] <= '0;
        pri_q[i]  <= '0;
      end
      for (int l = 0; l < LEVELS; l++) rr_q[l] <= '0;
    end else begin
      src_d     <= src_irq;
      edge_pend <= (edge_pend | (src_irq & ~src_d)) & ~clr;
      irq_out   <= any;
      vec_valid <= iack;
      if (iack) begin
        vec_out <= any ? win_vec : SPUR_VEC;
        if (any) rr_q[best_pri] <= win;
      end
      for (int i = 0; i < N_SRC; i++)
        if (cfg_we && cfg_addr == ADDR_W'(i)) begin
          base_q[i]    <= cfg_wdata[VEC_W-1:0];
          pri_q[i]     <= cfg_wdata[EN_B-1:VEC_W];
          en_q[i]      <= cfg_wdata[EN_B];
          edge_q[i]    <= cfg_wdata[EN_B+1];
          csel_q[i]    <= cfg_wdata[CFG_W-1];
          edge_pend[i] <= 1'b0;
        end
    end
  end
endmodule

// File: rtl/vpic_chk.sv
module vpic_chk #(
  parameter int N_SRC = 8,
  parameter int VEC_W = 8,
  parameter int IDX_W = 3,
  parameter logic [VEC_W-1:0] SPUR_VEC = '1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iack,
  input logic             cfg_we,
  input logic             irq_out,
  input logic             vec_valid,
  input logic [VEC_W-1:0] vec_out,
  input logic             any,
  input logic [IDX_W-1:0] win,
  input logic [N_SRC-1:0] pend,
  input logic [N_SRC-1:0] edge_q,
  input logic [N_SRC-1:0] en_q
);
  assert_req_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(|en_q));
  assert_ack_gives_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    iack |=> vec_valid);
  assert_vec_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !iack |=> $stable(vec_out));
  assert_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && !any) |=> vec_out == SPUR_VEC);
  assert_edge_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && any && edge_q[win] && !cfg_we) |=> !pend[$past(win)]);
endmodule

bind vpic vpic_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W), .IDX_W(IDX_W), .SPUR_VEC(SPUR_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .iack(iack), .cfg_we(cfg_we), .irq_out(irq_out),
  .vec_valid(vec_valid), .vec_out(vec_out), .any(any), .win(win), .pend(pend),
  .edge_q(edge_q), .en_q(en_q));

// File: tb/sim_vpic.sv
module sim_vpic;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  src_irq = '0;
  logic [15:0] src_cause = 16'h0030;
  logic [3:0]  cfg_addr = '0;
  logic        cfg_we = 0, iack = 0;
  logic [15:0] cfg_wdata = '0, cfg_rdata;
  logic        irq_out, vec_valid;
  logic [7:0]  vec_out;
  int tests = 0, fails = 0;

  vpic u0 (.clk(clk), .rst_n(rst_n), .src_irq(src_irq), .src_cause(src_cause),
    .cfg_addr(cfg_addr), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_out(irq_out), .iack(iack), .vec_valid(vec_valid), .vec_out(vec_out));

  always #2.5 clk = ~clk;

  localparam logic [15:0] CFG [8] = '{16'h0B40, 16'h0944, 16'h0B48, 16'h0D4C,
                                      16'h0850, 16'h0B54, 16'h0958, 16'h075C};
  // {input pattern, expected vector}
  localparam logic [15:0] TBL [10] = '{16'h0244, 16'h4258, 16'h4244, 16'h0A4C,
    16'h2548, 16'h2554, 16'h2540, 16'h90FF, 16'h2F4C, 16'h00FF};

  task automatic chk(input string req, input logic [15:0] act, exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); cfg_addr = a; cfg_wdata = d; cfg_we = 1;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    cfg_addr = a; #0.5; d = cfg_rdata;
  endtask

  task automatic ack();
    @(negedge clk); iack = 1;
    @(negedge clk); iack = 0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #100000;
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(4'd0, d); chk("R1 cfg0", d, 16'h0000);
    rd(4'd7, d); chk("R1 cfg7", d, 16'h0000);
    chk("R1 irq_out", irq_out, 0);
    chk("R1 vec_valid", vec_valid, 0);

    wr(4'd1, 16'hFFFF);
    rd(4'd1, d); chk("R2 readback", d, 16'h3FFF);

    for (int i = 0; i < 8; i++) wr(4'(i), CFG[i]);
    for (int i = 0; i < 8; i++) begin rd(4'(i), d); chk("R2 cfg", d, CFG[i]); end

    // R4, R5, R6, R7, R10 via table
    for (int t = 0; t < 10; t++) begin
      @(negedge clk); src_irq = TBL[t][15:8];
      @(negedge clk);
      chk("R5 irq_out", irq_out, TBL[t][7:0] != 8'hFF);
      ack();
      chk("R6 vec_valid", vec_valid, 1);
      chk("R6/R7/R10 vector", vec_out, TBL[t][7:0]);
    end
    @(negedge clk); chk("R6 vec_valid pulse", vec_valid, 0);
    chk("R6 vec held", vec_out, 8'hFF);

    // R3 and R11
    @(negedge clk); src_irq = 8'h80;
    @(negedge clk); rd(4'd8, d); chk("R11 pending", d, 16'h0080);
    chk("R3 disabled no irq", irq_out, 0);
    @(negedge clk); src_irq = 8'h05;
    @(negedge clk); rd(4'd8, d); chk("R11 pending", d, 16'h0005);

    // R8 cause insert on src2
    wr(4'd2, 16'h2B48);
    @(negedge clk); src_irq = 8'h04;
    @(negedge clk); ack();
    chk("R8 cause vector", vec_out, 8'h4B);

    // R9 edge mode on src6
    @(negedge clk); src_irq = 8'h00;
    wr(4'd6, 16'h1958);
    @(negedge clk); src_irq = 8'h40;
    @(negedge clk); rd(4'd8, d); chk("R9 edge latched", d, 16'h0040);
    @(negedge clk); chk("R9 irq_out", irq_out, 1);
    ack();
    chk("R9 vector", vec_out, 8'h58);
    rd(4'd8, d); chk("R9 cleared while held", d, 16'h0000);
    @(negedge clk); chk("R9 irq_out drops", irq_out, 0);
    @(negedge clk); src_irq = 8'h00;
    @(negedge clk); src_irq = 8'h40;
    @(negedge clk); rd(4'd8, d); chk("R9 new edge", d, 16'h0040);

    finish_run();
  end
endmodule